// File: doc/BRIEF.md
# Single-Cycle 16-bit Register-Pair Processor Core

This core is a small 16-bit processor. It keeps instruction memory and data memory apart and completes one instruction on every clock. On each cycle the program counter selects an instruction word. The word is decoded, and an arithmetic/logic result is formed from the data register and a second operand. That second operand is either the address register or the data word that the address register points at. On the next rising edge the result goes to any chosen mix of the address register, the data register and data memory.

The core has no internal memories. The instruction store and the data store sit outside it. Both are read combinationally: the instruction word and the data read word must arrive in the same cycle as the address the core drives. A data write is committed on the rising edge while the write enable is high. Branches always take their target from the address register, so software loads the target as a constant just before the branch word.

Top module: `stepcore`

## Requirements
- R1: A word with bit 15 = 0 is a constant load. At the next rising edge its low 15 bits, zero-extended, go into the address register, the data register keeps its value and the program counter advances by one. It never asserts the data write enable.
- R2: A word with bit 15 = 1 is a compute word. Bit 12 selects the second operand y (0 = address register, 1 = data read word), and x is always the data register. Bits 11..6 are, from high to low: clear x, invert x, clear y, invert y, add (1) or bitwise AND (0), invert the result. They are applied in that order.
- R3: In a compute word, bit 5 writes the result into the address register, bit 4 into the data register and bit 3 into data memory. Any mix may be set. The memory write uses the address register value from before the edge, the result as write data, and a write enable that is high during that cycle.
- R4: In a compute word, bits 2, 1 and 0 select a branch when the result is negative, zero or positive (strictly above zero) respectively. If any selected condition holds, the next program counter is the low 15 bits of the address register held before the edge. Otherwise it is the program counter plus one, wrapping from 0x7FFF to 0.
- R5: The instruction address output is the program counter, and exactly one instruction completes per clock.
- R6: While the synchronous active-high reset is high, the data write enable is low. At the reset edge the program counter, address register and data register are cleared to zero.
- R7: The data address output always shows the low 15 bits of the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 15 | Instruction address (program counter) |
| imem_data | input | 16 | Instruction word for imem_addr, same cycle |
| dmem_addr | output | 15 | Data address, from the address register |
| dmem_wdata | output | 16 | Result to be written to data memory |
| dmem_we | output | 1 | Data write enable, committed on the rising edge |
| dmem_rdata | input | 16 | Data word at dmem_addr, same cycle |

## Verification
The bound checker watches every cycle for these rules: constant loads never write memory, always advance the program counter and land their constant in the address register. Words with no branch bits advance the program counter, and words with all branch bits set jump to the old address register. The address output holds still when the destination leaves the address register out. Reset clears the visible state and blocks writes. The arithmetic of each function code and the value that reaches the data register can only be seen through the bench's scenarios. The same holds for branch decisions that depend on the result's sign or zero state, and for the program counter wrapping at the top of the address space. The bench runs a short program against modelled instruction and data stores, then drives instruction words directly to reach these corners.

// File: rtl/stepcore_pkg.sv
package stepcore_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = DATA_W - 1;
    localparam int ALU_CTL_W = 6;

    typedef enum logic {
        K_CONST   = 1'b0,
        K_COMPUTE = 1'b1
    } kind_e;

    typedef struct packed {
        logic zx;
        logic nx;
        logic zy;
        logic ny;
        logic add;
        logic inv;
    } alu_ctl_t;

    typedef struct packed {
        logic to_a;
        logic to_d;
        logic to_mem;
    } dest_t;

    typedef struct packed {
        logic on_neg;
        logic on_zero;
        logic on_pos;
    } cond_t;

    typedef struct packed {
        kind_e               kind;
        logic                y_from_mem;
        alu_ctl_t            alu;
        dest_t               dst;
        cond_t               cond;
        logic [ADDR_W-1:0]   imm;
    } ctl_t;

    function automatic logic cond_met(cond_t c, logic zr, logic ng);
        return (c.on_neg & ng) | (c.on_zero & zr) | (c.on_pos & ~ng & ~zr);
    endfunction

endpackage

// File: rtl/stepcore_decode.sv
module stepcore_decode
    import stepcore_pkg::*;
(
    input  logic [DATA_W-1:0] instr,
    output ctl_t              ctl
);

    logic is_c;

    assign is_c = instr[DATA_W-1];

    always_comb begin
        ctl.kind       = kind_e'(is_c);
        ctl.y_from_mem = instr[12];
        ctl.alu        = alu_ctl_t'(instr[11:6]);
        // A constant word must not enable any destination or branch.
        ctl.dst        = is_c ? dest_t'(instr[5:3]) : '0;
        ctl.cond       = is_c ? cond_t'(instr[2:0]) : '0;
        ctl.imm        = instr[ADDR_W-1:0];
    end

endmodule

// File: rtl/stepcore_alu.sv
module stepcore_alu
    import stepcore_pkg::*;
(
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  alu_ctl_t          op,
    output logic [DATA_W-1:0] res,
    output logic              zr,
    output logic              ng
);

    logic [DATA_W-1:0] xs, ys, raw;

    always_comb begin
        xs  = op.zx ? '0 : x;
        xs  = op.nx ? ~xs : xs;
        ys  = op.zy ? '0 : y;
        ys  = op.ny ? ~ys : ys;
        raw = op.add ? (xs + ys) : (xs & ys);
        res = op.inv ? ~raw : raw;
    end

    assign zr = (res == '0);
    assign ng = res[DATA_W-1];

endmodule

// File: rtl/stepcore_state.sv
module stepcore_state
    import stepcore_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic [DATA_W-1:0] a_nxt,
    input  logic              d_en,
    input  logic [DATA_W-1:0] d_nxt,
    input  logic [ADDR_W-1:0] pc_nxt,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] d_q,
    output logic [ADDR_W-1:0] pc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            d_q  <= '0;
            pc_q <= '0;
        end else begin
            if (a_en) a_q <= a_nxt;
            if (d_en) d_q <= d_nxt;
            pc_q <= pc_nxt;
        end
    end

endmodule

// File: rtl/stepcore.sv
module stepcore
    import stepcore_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [DATA_W-1:0] imem_data,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic              dmem_we,
    input  logic [DATA_W-1:0] dmem_rdata
);

    ctl_t              ctl;
    logic [DATA_W-1:0] a_q, d_q, pc_ext;
    logic [ADDR_W-1:0] pc_q, pc_nxt;
    logic [DATA_W-1:0] y_op, alu_res, a_nxt;
    logic              zr, ng, is_c, take;

    stepcore_decode u_dec (
        .instr (imem_data),
        .ctl   (ctl)
    );

    assign is_c = (ctl.kind == K_COMPUTE);
    assign y_op = ctl.y_from_mem ? dmem_rdata : a_q;

    stepcore_alu u_alu (
        .x   (d_q),
        .y   (y_op),
        .op  (ctl.alu),
        .res (alu_res),
        .zr  (zr),
        .ng  (ng)
    );

    assign a_nxt  = is_c ? alu_res : DATA_W'(ctl.imm);
    assign take   = cond_met(ctl.cond, zr, ng);
    assign pc_ext = DATA_W'(pc_q) + DATA_W'(1);
    assign pc_nxt = take ? a_q[ADDR_W-1:0] : pc_ext[ADDR_W-1:0];

    stepcore_state u_state (
        .clk    (clk),
        .rst    (rst),
        .a_en   (~is_c | ctl.dst.to_a),
        .a_nxt  (a_nxt),
        .d_en   (ctl.dst.to_d),
        .d_nxt  (alu_res),
        .pc_nxt (pc_nxt),
        .a_q    (a_q),
        .d_q    (d_q),
        .pc_q   (pc_q)
    );

    assign imem_addr  = pc_q;
    assign dmem_addr  = a_q[ADDR_W-1:0];
    assign dmem_wdata = alu_res;
    assign dmem_we    = ctl.dst.to_mem & ~rst;

endmodule

// File: rtl/stepcore_chk.sv
module stepcore_chk
    import stepcore_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] imem_addr,
    input logic [DATA_W-1:0] imem_data,
    input logic [ADDR_W-1:0] dmem_addr,
    input logic              dmem_we
);

    // R6: no write enable while reset is held
    always_comb begin
        if (rst) begin
            a_r6_no_write_in_reset: assert (!dmem_we);
        end
    end

    // R6: state visible as zero in the first cycle out of reset
    a_r6_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (imem_addr == '0 && dmem_addr == '0));

    // R1: constant loads never write memory
    a_r1_const_no_write: assert property (@(posedge clk) disable iff (rst)
        !imem_data[DATA_W-1] |-> !dmem_we);

    // R1: constant lands in the address register
    a_r1_const_loads_a: assert property (@(posedge clk) disable iff (rst)
        !imem_data[DATA_W-1] |=> dmem_addr == $past(imem_data[ADDR_W-1:0]));

    // R1: constant loads advance the program counter
    a_r1_const_pc_step: assert property (@(posedge clk) disable iff (rst)
        !imem_data[DATA_W-1] |=> imem_addr == ADDR_W'($past(imem_addr) + 1'b1));

    // R4: no branch bits -> sequential
    a_r4_never_branch: assert property (@(posedge clk) disable iff (rst)
        (imem_data[DATA_W-1] && imem_data[2:0] == 3'b000)
        |=> imem_addr == ADDR_W'($past(imem_addr) + 1'b1));

    // R4: all branch bits -> target from old address register
    a_r4_always_branch: assert property (@(posedge clk) disable iff (rst)
        (imem_data[DATA_W-1] && imem_data[2:0] == 3'b111)
        |=> imem_addr == $past(dmem_addr));

    // R3/R7: address register untouched when not a destination
    a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
        (imem_data[DATA_W-1] && !imem_data[5]) |=> $stable(dmem_addr));

endmodule

bind stepcore stepcore_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_addr (dmem_addr),
    .dmem_we   (dmem_we)
);

// File: tb/test_stepcore.sv
`timescale 1ns/1ps
module test_stepcore;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] imem_addr;
    logic [15:0] imem_data;
    logic [14:0] dmem_addr;
    logic [15:0] dmem_wdata;
    logic        dmem_we;
    logic [15:0] dmem_rdata;

    logic        use_rom = 1'b1;
    logic [15:0] drv_instr = 16'h0000;
    logic [15:0] ram [256];
    int          checks = 0;
    int          fails  = 0;

    always #10 clk = ~clk;

    // Program store: 16 words
    localparam logic [15:0] ROM [16] = '{
        16'h0005, 16'hEC10, 16'h0064, 16'hE308,
        16'hFDD0, 16'hE3B8, 16'h000A, 16'hE304,
        16'hE301, 16'hEE88, 16'hEE88, 16'hF010,
        16'hE548, 16'h0000, 16'hEA87, 16'h0000
    };

    // Per-step expectation: {pc, addr, we, wdata}
    localparam int NSTEP = 16;
    localparam logic [46:0] VEC [NSTEP] = '{
        {15'd0,   15'd0,   1'b0, 16'h0000},
        {15'd1,   15'd5,   1'b0, 16'h0000},
        {15'd2,   15'd5,   1'b0, 16'h0000},
        {15'd3,   15'd100, 1'b1, 16'h0005},
        {15'd4,   15'd100, 1'b0, 16'h0000},
        {15'd5,   15'd100, 1'b1, 16'h0005},
        {15'd6,   15'd5,   1'b0, 16'h0000},
        {15'd7,   15'd10,  1'b0, 16'h0000},
        {15'd8,   15'd10,  1'b0, 16'h0000},
        {15'd10,  15'd10,  1'b1, 16'hFFFF},
        {15'd11,  15'd10,  1'b0, 16'h0000},
        {15'd12,  15'd10,  1'b1, 16'h000F},
        {15'd13,  15'd10,  1'b0, 16'h0000},
        {15'd14,  15'd0,   1'b0, 16'h0000},
        {15'd0,   15'd0,   1'b0, 16'h0000},
        {15'd1,   15'd5,   1'b0, 16'h0000}
    };

    assign imem_data  = use_rom ? ROM[imem_addr[3:0]] : drv_instr;
    assign dmem_rdata = ram[dmem_addr[7:0]];

    initial begin
        for (int k = 0; k < 256; k++) ram[k] = 16'h0000;
    end

    always @(posedge clk) begin
        if (dmem_we) ram[dmem_addr[7:0]] <= dmem_wdata;
    end

    stepcore i_stepcore (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one directed word at a negedge, settle, leave the edge to the caller.
    task automatic put(input logic r, input logic [15:0] w);
        rst = r;
        drv_instr = w;
        #5;
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R6 pc cleared in reset", 32'(imem_addr), 32'd0);
        chk("R6 addr cleared in reset", 32'(dmem_addr), 32'd0);
        chk("R6 no write in reset", 32'(dmem_we), 32'd0);
        rst = 1'b0;
        #5;

        // Program walk: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < NSTEP; i++) begin
            chk($sformatf("R5 pc step %0d", i), 32'(imem_addr), 32'(VEC[i][46:32]));
            chk($sformatf("R7 addr step %0d", i), 32'(dmem_addr), 32'(VEC[i][31:17]));
            chk($sformatf("R3 we step %0d", i), 32'(dmem_we), 32'(VEC[i][16]));
            if (VEC[i][16])
                chk($sformatf("R2 result step %0d", i), 32'(dmem_wdata), 32'(VEC[i][15:0]));
            @(negedge clk);
            #5;
        end
        chk("R3 memory write of AMD result", 32'(ram[100]), 32'h0005);
        chk("R3 memory write of D|A", 32'(ram[10]), 32'h000F);

        // Directed corners
        @(negedge clk);
        use_rom = 1'b0;
        put(1'b1, 16'hEE88);
        chk("R6 write blocked during reset", 32'(dmem_we), 32'd0);
        @(negedge clk);
        put(1'b0, 16'hE308);
        chk("R6 pc zero after reset", 32'(imem_addr), 32'd0);
        chk("R6 A zero after reset", 32'(dmem_addr), 32'd0);
        chk("R6 D zero after reset", 32'(dmem_wdata), 32'h0000);
        chk("R3 write enable from dest bit", 32'(dmem_we), 32'd1);
        @(negedge clk);
        put(1'b0, 16'h7FFF);
        chk("R1 const word no write", 32'(dmem_we), 32'd0);
        chk("R1 pc after write word", 32'(imem_addr), 32'd1);
        @(negedge clk);
        put(1'b0, 16'hE308);
        chk("R1 const loaded to A", 32'(dmem_addr), 32'h7FFF);
        chk("R1 D unchanged by const", 32'(dmem_wdata), 32'h0000);
        chk("R1 const pc step", 32'(imem_addr), 32'd2);
        @(negedge clk);
        put(1'b0, 16'hEA82);
        chk("R4 pc before JEQ", 32'(imem_addr), 32'd3);
        @(negedge clk);
        put(1'b0, 16'hEA85);
        chk("R4 zero-branch taken to A", 32'(imem_addr), 32'h7FFF);
        @(negedge clk);
        put(1'b0, 16'hEE84);
        chk("R4 not-zero untaken, pc wraps", 32'(imem_addr), 32'd0);
        @(negedge clk);
        put(1'b0, 16'hEE81);
        chk("R4 negative branch taken", 32'(imem_addr), 32'h7FFF);
        @(negedge clk);
        put(1'b0, 16'h0003);
        chk("R4 positive untaken on negative, wrap", 32'(imem_addr), 32'd0);
        @(negedge clk);
        put(1'b0, 16'hEE90);
        chk("R1 A loaded with 3", 32'(dmem_addr), 32'd3);
        @(negedge clk);
        put(1'b0, 16'hE4C8);
        chk("R2 D-A", 32'(dmem_wdata), 32'hFFFC);
        @(negedge clk);
        put(1'b0, 16'hE1C8);
        chk("R2 A-D", 32'(dmem_wdata), 32'h0004);
        @(negedge clk);
        put(1'b0, 16'hE348);
        chk("R2 not D", 32'(dmem_wdata), 32'h0000);
        @(negedge clk);
        put(1'b0, 16'hECC8);
        chk("R2 negate A", 32'(dmem_wdata), 32'hFFFD);
        chk("R3 A held without A dest", 32'(dmem_addr), 32'd3);
        chk("R5 pc sequential", 32'(imem_addr), 32'd5);
        @(negedge clk);
        put(1'b0, 16'hE302);
        chk("R5 pc before D;JEQ", 32'(imem_addr), 32'd6);
        @(negedge clk);
        put(1'b0, 16'hE7E0);
        chk("R4 zero-branch untaken on nonzero", 32'(imem_addr), 32'd7);
        @(negedge clk);
        put(1'b0, 16'h0000);
        chk("R3 result written to A only", 32'(dmem_addr), 32'd0);
        chk("R5 pc after A-dest word", 32'(imem_addr), 32'd8);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule